// File: doc/BRIEF.md
# Selectable NRZ / NRZI Serial Line Codec

This block sits on one synchronous serial channel, between the bit-level data path and the physical line. On the transmit side it turns one data bit into a line level on each transmit bit-clock enable. On the receive side it turns one sampled line level into a data bit on each receive bit-clock enable. Four codings are available: level coding, inverted level coding, differential coding where a 0 is sent as a change of line level, and the inverted differential variant.

When the transmit side is stepped with no valid bit, the line carries an idle pattern instead: held low, held high, or toggling on every step. The idle level drives the line directly and does not pass through the encoder. Holding the line at a constant level cannot be told apart from data under a differential coding. The block therefore flags that pairing as a configuration error and toggles the line instead.

The coding and idle selections are captured only while the channel enable is low, so a bit is never coded with a mixture of two settings. Clock recovery, framing and sync detection live elsewhere.

Top module: `line_codec_top`

## Requirements
- R1: With coding code 00 (level), a transmit step with valid data sets `tx_line` to the bit, and a receive step yields `rx_bit` equal to the sampled `rx_line`.
- R2: With coding code 01 (inverted level), a transmit step with valid data sets `tx_line` to the complement of the bit, and a receive step yields the complement of `rx_line`.
- R3: With coding code 10 (differential), a transmit bit 0 inverts `tx_line` and a bit 1 keeps it. With code 11 (inverted differential), a 1 inverts and a 0 keeps it.
- R4: With code 10, a received level that differs from the level taken at the previous receive step decodes to 0 and an equal level decodes to 1. With code 11 the result is swapped. The stored previous receive level resets to 1 and is refreshed on every receive step, in every coding.
- R5: A transmit step with `tx_valid` low drives the idle pattern, uncoded: idle code 00 drives 0, idle code 01 drives 1, and idle codes 10 and 11 invert the line.
- R6: While a differential coding (10 or 11) is combined with idle code 00 or 01, `cfg_error` is high and the idle steps toggle the line. For every other pairing `cfg_error` is low.
- R7: `tx_line` resets to 1 and changes only on a transmit step. Idle steps also set the reference level for the next differentially coded bit.
- R8: `rx_bit_vld` is high for exactly the one cycle after each receive step, with `rx_bit` holding that step's decoded bit. It is low after reset.
- R9: Coding and idle selections are captured on each clock while `chan_en` is low, and after reset they default to level coding with toggling idle. Changes while `chan_en` is high have no effect. While `chan_en` is low, both bit-clock enables are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_en | input | 1 | Channel enable; low lets the selections load |
| code_sel | input | 2 | Coding: 00 level, 01 inverted level, 10 differential, 11 inverted differential |
| idle_sel | input | 2 | Idle: 00 low, 01 high, 10/11 toggling |
| tx_bit_en | input | 1 | Transmit bit-clock enable |
| tx_valid | input | 1 | Transmit bit present; low selects idle |
| tx_bit | input | 1 | Transmit data bit |
| tx_line | output | 1 | Line level driven out |
| rx_bit_en | input | 1 | Receive bit-clock enable |
| rx_line | input | 1 | Sampled line level |
| rx_bit | output | 1 | Decoded receive bit |
| rx_bit_vld | output | 1 | Decoded bit valid strobe |
| cfg_error | output | 1 | Illegal coding/idle pairing in force |

## Verification
The properties assume that the selections captured while the channel is disabled stay in force for the whole enabled period. They also assume that a bit-clock enable and its data are sampled together at one edge. The stimulus reconfigures the block only with the channel enable dropped for a full clock. It drives each bit together with its enable half a cycle before the edge. It also changes the selection pins once while the channel is enabled, to show that the change is ignored. Receive and transmit steps are issued separately, so the reference level that each direction keeps can be predicted step by step.

// File: rtl/line_codec_pkg.sv
package line_codec_pkg;

  typedef enum logic [1:0] {
    CODE_LVL      = 2'b00,
    CODE_LVL_INV  = 2'b01,
    CODE_DIFF     = 2'b10,
    CODE_DIFF_INV = 2'b11
  } code_e;

  typedef enum logic [1:0] {
    IDLE_LOW  = 2'b00,
    IDLE_HIGH = 2'b01,
    IDLE_TOG  = 2'b10,
    IDLE_TOG2 = 2'b11
  } idle_e;

  // bit 1 of the coding selects differential, bit 0 selects inversion
  function automatic logic is_diff(input code_e c);
    return c[1];
  endfunction

  function automatic logic encode_bit(input code_e c, input logic b, input logic prev);
    logic d;
    d = b ^ c[0];
    if (is_diff(c)) return d ? prev : ~prev;
    return d;
  endfunction

  function automatic logic decode_level(input code_e c, input logic lvl, input logic prev);
    if (is_diff(c)) return (lvl == prev) ^ c[0];
    return lvl ^ c[0];
  endfunction

  function automatic logic idle_level(input idle_e i, input logic prev);
    case (i)
      IDLE_LOW:  return 1'b0;
      IDLE_HIGH: return 1'b1;
      default:   return ~prev;
    endcase
  endfunction

  function automatic logic pair_illegal(input code_e c, input idle_e i);
    return is_diff(c) && !i[1];
  endfunction

endpackage

// File: rtl/line_codec_cfg.sv
module line_codec_cfg
  import line_codec_pkg::*;
#(
  parameter code_e DEF_CODE = CODE_LVL,
  parameter idle_e DEF_IDLE = IDLE_TOG
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       chan_en,
  input  logic [1:0] code_in,
  input  logic [1:0] idle_in,
  output code_e      code_q,
  output idle_e      idle_eff,
  output logic       cfg_bad
);
  idle_e idle_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= DEF_CODE;
      idle_q <= DEF_IDLE;
    end else if (!chan_en) begin
      code_q <= code_e'(code_in);
      idle_q <= idle_e'(idle_in);
    end
  end

  always_comb begin
    cfg_bad  = pair_illegal(code_q, idle_q);
    idle_eff = cfg_bad ? IDLE_TOG : idle_q;
  end
endmodule

// File: rtl/line_codec_tx.sv
module line_codec_tx
  import line_codec_pkg::*;
#(
  parameter logic LINE_RST = 1'b1
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  step,
  input  logic  valid,
  input  logic  bit_in,
  input  code_e code,
  input  idle_e idle,
  output logic  line_q
);
  logic line_nxt;

  always_comb begin
    line_nxt = valid ? encode_bit(code, bit_in, line_q) : idle_level(idle, line_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    line_q <= LINE_RST;
    else if (step) line_q <= line_nxt;
  end
endmodule

// File: rtl/line_codec_rx.sv
module line_codec_rx
  import line_codec_pkg::*;
#(
  parameter logic LINE_RST = 1'b1
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  step,
  input  logic  lvl,
  input  code_e code,
  output logic  prev_q,
  output logic  bit_q,
  output logic  vld_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= LINE_RST;
      bit_q  <= 1'b0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= step;
      if (step) begin
        bit_q  <= decode_level(code, lvl, prev_q);
        prev_q <= lvl;
      end
    end
  end
endmodule

// File: rtl/line_codec_top.sv
module line_codec_top
  import line_codec_pkg::*;
#(
  parameter logic  LINE_RST = 1'b1,
  parameter code_e DEF_CODE = CODE_LVL,
  parameter idle_e DEF_IDLE = IDLE_TOG
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       chan_en,
  input  logic [1:0] code_sel,
  input  logic [1:0] idle_sel,
  input  logic       tx_bit_en,
  input  logic       tx_valid,
  input  logic       tx_bit,
  output logic       tx_line,
  input  logic       rx_bit_en,
  input  logic       rx_line,
  output logic       rx_bit,
  output logic       rx_bit_vld,
  output logic       cfg_error
);
  code_e code_q;
  idle_e idle_eff;
  logic  tx_step;
  logic  rx_step;
  logic  rx_prev;

  assign tx_step = chan_en & tx_bit_en;
  assign rx_step = chan_en & rx_bit_en;

  line_codec_cfg #(.DEF_CODE(DEF_CODE), .DEF_IDLE(DEF_IDLE)) u_cfg (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en),
    .code_in(code_sel), .idle_in(idle_sel),
    .code_q(code_q), .idle_eff(idle_eff), .cfg_bad(cfg_error)
  );

  line_codec_tx #(.LINE_RST(LINE_RST)) u_tx (
    .clk(clk), .rst_n(rst_n), .step(tx_step), .valid(tx_valid),
    .bit_in(tx_bit), .code(code_q), .idle(idle_eff), .line_q(tx_line)
  );

  line_codec_rx #(.LINE_RST(LINE_RST)) u_rx (
    .clk(clk), .rst_n(rst_n), .step(rx_step), .lvl(rx_line),
    .code(code_q), .prev_q(rx_prev), .bit_q(rx_bit), .vld_q(rx_bit_vld)
  );
endmodule

// File: rtl/line_codec_chk.sv
module line_codec_chk
  import line_codec_pkg::*;
(
  input logic  clk,
  input logic  rst_n,
  input logic  chan_en,
  input logic  tx_step,
  input logic  rx_step,
  input logic  tx_valid,
  input logic  tx_bit,
  input logic  tx_line,
  input logic  rx_line,
  input logic  rx_prev,
  input logic  rx_bit,
  input logic  rx_bit_vld,
  input logic  cfg_error,
  input code_e code_q,
  input idle_e idle_eff
);
  assert_tx_lvl_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_step && tx_valid && code_q == CODE_LVL) |=> (tx_line == $past(tx_bit)));

  assert_rx_lvl_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_step && code_q == CODE_LVL) |=> (rx_bit == $past(rx_line)));

  assert_tx_inv_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_step && tx_valid && code_q == CODE_LVL_INV) |=> (tx_line != $past(tx_bit)));

  assert_tx_diff_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_step && tx_valid && code_q == CODE_DIFF) |=>
      (tx_line == ($past(tx_bit) ? $past(tx_line) : !$past(tx_line))));

  assert_rx_diff_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_step && code_q == CODE_DIFF) |=> (rx_bit == ($past(rx_line) == $past(rx_prev))));

  assert_idle_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_step && !tx_valid && idle_eff == IDLE_LOW) |=> !tx_line);

  assert_idle_fix_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_step && !tx_valid && cfg_error) |=> (tx_line != $past(tx_line)));

  assert_err_diff_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_error |-> (code_q == CODE_DIFF || code_q == CODE_DIFF_INV));

  assert_tx_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_step |=> $stable(tx_line));

  assert_vld_on_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_step |=> rx_bit_vld);

  assert_vld_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_step |=> !rx_bit_vld);

  assert_cfg_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    chan_en |=> $stable(code_q));

  assert_off_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_en |=> ($stable(tx_line) && !rx_bit_vld));
endmodule

bind line_codec_top line_codec_chk u_chk (
  .clk(clk), .rst_n(rst_n), .chan_en(chan_en),
  .tx_step(tx_step), .rx_step(rx_step),
  .tx_valid(tx_valid), .tx_bit(tx_bit), .tx_line(tx_line),
  .rx_line(rx_line), .rx_prev(rx_prev), .rx_bit(rx_bit),
  .rx_bit_vld(rx_bit_vld), .cfg_error(cfg_error),
  .code_q(code_q), .idle_eff(idle_eff)
);

// File: tb/tb_line_codec_top.sv
module tb_line_codec_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       chan_en = 1'b0;
  logic [1:0] code_sel = 2'b00;
  logic [1:0] idle_sel = 2'b10;
  logic       tx_bit_en = 1'b0;
  logic       tx_valid = 1'b0;
  logic       tx_bit = 1'b0;
  logic       tx_line;
  logic       rx_bit_en = 1'b0;
  logic       rx_line = 1'b0;
  logic       rx_bit;
  logic       rx_bit_vld;
  logic       cfg_error;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // bench model
  logic [1:0] m_code = 2'b00;
  logic [1:0] m_idle = 2'b10;
  logic       m_tx = 1'b1;
  logic       m_rx = 1'b1;

  // scoreboard
  bit    q_rx[$];
  logic  q_val[$];
  string q_req[$];

  always #5 clk = ~clk;

  line_codec_top dut (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en),
    .code_sel(code_sel), .idle_sel(idle_sel),
    .tx_bit_en(tx_bit_en), .tx_valid(tx_valid), .tx_bit(tx_bit), .tx_line(tx_line),
    .rx_bit_en(rx_bit_en), .rx_line(rx_line), .rx_bit(rx_bit),
    .rx_bit_vld(rx_bit_vld), .cfg_error(cfg_error)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic exp_line(input logic [1:0] c, input logic b, input logic p);
    case (c)
      2'b00: return b;
      2'b01: return !b;
      2'b10: return (b == 1'b1) ? p : !p;
      default: return (b == 1'b1) ? !p : p;
    endcase
  endfunction

  function automatic logic exp_bit(input logic [1:0] c, input logic l, input logic p);
    case (c)
      2'b00: return l;
      2'b01: return !l;
      2'b10: return (l === p) ? 1'b1 : 1'b0;
      default: return (l !== p) ? 1'b1 : 1'b0;
    endcase
  endfunction

  function automatic logic exp_idle(input logic [1:0] c, input logic [1:0] i, input logic p);
    if (i == 2'b00 && c < 2'b10) return 1'b0;
    if (i == 2'b01 && c < 2'b10) return 1'b1;
    return !p;
  endfunction

  // monitor: pops every expectation pushed before this edge
  always @(posedge clk) begin
    #1;
    while (q_rx.size() > 0) begin
      bit k; logic v; string r;
      k = q_rx.pop_front(); v = q_val.pop_front(); r = q_req.pop_front();
      if (k) begin
        chk({r, " rx_bit_vld"}, int'(rx_bit_vld), 1);
        chk({r, " rx_bit"}, int'(rx_bit), int'(v));
      end else begin
        chk({r, " tx_line"}, int'(tx_line), int'(v));
      end
    end
  end

  task automatic quiet();
    @(negedge clk);
    tx_bit_en = 1'b0; rx_bit_en = 1'b0; tx_valid = 1'b0;
  endtask

  task automatic tx_one(input logic v, input logic b, input string req);
    @(negedge clk);
    rx_bit_en = 1'b0; tx_bit_en = 1'b1; tx_valid = v; tx_bit = b;
    m_tx = v ? exp_line(m_code, b, m_tx) : exp_idle(m_code, m_idle, m_tx);
    q_rx.push_back(1'b0); q_val.push_back(m_tx); q_req.push_back(req);
    @(posedge clk);
    quiet();
  endtask

  task automatic rx_one(input logic l, input string req);
    @(negedge clk);
    tx_bit_en = 1'b0; rx_bit_en = 1'b1; rx_line = l;
    q_rx.push_back(1'b1); q_val.push_back(exp_bit(m_code, l, m_rx)); q_req.push_back(req);
    m_rx = l;
    @(posedge clk);
    quiet();
  endtask

  task automatic set_cfg(input logic [1:0] c, input logic [1:0] i);
    @(negedge clk);
    chan_en = 1'b0; code_sel = c; idle_sel = i;
    @(negedge clk);
    chan_en = 1'b1;
    m_code = c; m_idle = i;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R7 reset tx_line", int'(tx_line), 1);
    chk("R8 reset rx_bit_vld", int'(rx_bit_vld), 0);
    chk("R6 reset cfg_error", int'(cfg_error), 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); chan_en = 1'b1;

    // R9 default after reset: level coding, toggling idle
    tx_one(1'b1, 1'b0, "R9 default coding");
    tx_one(1'b0, 1'b0, "R9 default idle");

    set_cfg(2'b00, 2'b01);
    tx_one(1'b1, 1'b1, "R1"); tx_one(1'b1, 1'b0, "R1"); tx_one(1'b1, 1'b0, "R1"); tx_one(1'b1, 1'b1, "R1");
    rx_one(1'b0, "R1"); rx_one(1'b1, "R1"); rx_one(1'b1, "R1");
    #1 chk("R6 legal pair cfg_error", int'(cfg_error), 0);

    set_cfg(2'b01, 2'b00);
    tx_one(1'b1, 1'b1, "R2"); tx_one(1'b1, 1'b0, "R2");
    rx_one(1'b0, "R2"); rx_one(1'b1, "R2");

    set_cfg(2'b10, 2'b10);
    tx_one(1'b1, 1'b0, "R3"); tx_one(1'b1, 1'b0, "R3"); tx_one(1'b1, 1'b1, "R3");
    tx_one(1'b1, 1'b0, "R3"); tx_one(1'b1, 1'b1, "R3");
    rx_one(1'b1, "R4"); rx_one(1'b1, "R4"); rx_one(1'b0, "R4"); rx_one(1'b0, "R4"); rx_one(1'b1, "R4");

    set_cfg(2'b11, 2'b11);
    tx_one(1'b1, 1'b1, "R3 inv"); tx_one(1'b1, 1'b0, "R3 inv"); tx_one(1'b1, 1'b1, "R3 inv");
    rx_one(1'b1, "R4 inv"); rx_one(1'b0, "R4 inv"); rx_one(1'b0, "R4 inv");

    // idle patterns, uncoded
    set_cfg(2'b01, 2'b00);
    tx_one(1'b0, 1'b1, "R5 idle low"); tx_one(1'b0, 1'b1, "R5 idle low");
    set_cfg(2'b01, 2'b01);
    tx_one(1'b0, 1'b0, "R5 idle high");
    set_cfg(2'b10, 2'b10);
    tx_one(1'b0, 1'b0, "R5 idle toggle"); tx_one(1'b0, 1'b0, "R5 idle toggle");
    tx_one(1'b0, 1'b0, "R5 idle toggle");
    tx_one(1'b1, 1'b0, "R7 data after idle"); tx_one(1'b1, 1'b1, "R7 data after idle");

    // illegal pairings
    set_cfg(2'b10, 2'b00);
    #1 chk("R6 cfg_error diff+low", int'(cfg_error), 1);
    tx_one(1'b0, 1'b0, "R6 forced toggle"); tx_one(1'b0, 1'b0, "R6 forced toggle");
    set_cfg(2'b11, 2'b01);
    #1 chk("R6 cfg_error inv diff+high", int'(cfg_error), 1);
    tx_one(1'b0, 1'b0, "R6 forced toggle");

    // selection changes while enabled are ignored
    set_cfg(2'b00, 2'b01);
    @(negedge clk); code_sel = 2'b01; idle_sel = 2'b00;
    tx_one(1'b1, 1'b1, "R9 change ignored");
    tx_one(1'b0, 1'b0, "R9 change ignored idle");
    #1 chk("R9 cfg_error unchanged", int'(cfg_error), 0);
    code_sel = 2'b00; idle_sel = 2'b01;

    // disabled channel ignores enables
    @(negedge clk);
    chan_en = 1'b0; tx_bit_en = 1'b1; tx_valid = 1'b1; tx_bit = !m_tx;
    rx_bit_en = 1'b1; rx_line = !m_rx;
    @(posedge clk); #1;
    chk("R9 disabled tx_line", int'(tx_line), int'(m_tx));
    chk("R9 disabled rx_bit_vld", int'(rx_bit_vld), 0);
    quiet();
    @(negedge clk); chan_en = 1'b1;
    rx_one(m_rx, "R9 rx reference kept");

    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule